// File: doc/BRIEF.md
# PoE Powered-Device Startup Sequencer

This block is a clocked supervisor for the power path of a device fed from a PoE input. It does not measure anything itself. It reads already synchronized comparator flags for the input voltage, the converter bias rail (VCC), the soft-start capacitor, the inrush current and the thermal state. From these flags it drives the enables of the input hotswap switch and of the DC-DC converter. It also selects the hotswap current limit, gates the VCC startup current source, and commands discharge or charge of the soft-start capacitor.

A start proceeds in order. The hotswap closes in its low inrush limit. It moves to the operational limit once the inrush current has settled. After a minimum inrush time, with VCC charged, the soft-start capacitor is first pre-discharged and then recharged. Switching is enabled at a threshold that depends on the feedback mode. The startup source is released near the end of the soft-start.

A VCC collapse stops the converter, and the block then restarts from the pre-discharge (hiccup). A light-load VCC dip is handled differently: the startup source is enabled briefly and the soft-start is not repeated. Losing the input switches off the hotswap. The converter keeps running unless the line monitor also reports undervoltage.

Top module: `pd_start_seq`

## Requirements
- R1: After reset every output is 0. The hotswap stays off (hs_en=0) while vin_on=0, whatever the level of vin_hold.
- R2: One clock edge after vin_on=1 is seen with the hotswap off, hs_en=1 and ilim_oper=0 (0 = inrush limit, 1 = operational limit). One edge after hs_en rises, start_en=1. Whenever the hotswap is in its inrush limit, sw_en is 0 from the following edge on.
- R3: While the hotswap is in its inrush limit, ilim_oper becomes 1 on the edge after inrush_ok=1 is seen.
- R4: The soft-start pre-discharge (ss_dis=1) does not begin before all of the following hold: INRUSH_CYC = CLK_HZ/1000*INRUSH_MS edges have passed since the edge on which hs_en rose; ilim_oper=1; vcc_rise=1. It begins on the edge after these conditions first hold together.
- R5: Every converter start begins with ss_dis=1 and start_en=1. The block then moves to ss_chg=1 with ss_dis=0 on the edge after ss_low=1 is seen. Pre-discharge occurs even if the capacitor flags already read high.
- R6: While charging, fb_mode=0 uses the ss_psr flag and fb_mode=1 uses the ss_opto flag. On the edge after the selected flag is 1, sw_en=1. The unselected flag has no effect.
- R7: While switching with the startup source on, start_en drops to 0 on the edge after ss_done=1 is seen. sw_en and ss_chg stay at 1.
- R8: When vcc_fall=0 is seen while the converter is active, sw_en, ss_chg and ss_dis go to 0 on the next edge, and start_en follows hs_en. If the start conditions of R4 hold again, the next start repeats the full sequence beginning with ss_dis=1 (hiccup).
- R9: In steady running, vcc_mid=0 with vcc_fall=1 turns start_en on at the next edge, with no change to sw_en, ss_chg or ss_dis. This top-up lasts TOPUP_CYC cycles, or ends on the edge after vcc_rise=1 is seen, whichever comes first.
- R10: On the edge after vin_hold=0, hs_en=0 and ilim_oper=0. A running converter keeps sw_en=1 while line_ok=1, and stops on the edge after line_ok=0 is seen with the hotswap off.
- R11: The converter stops on the edge after any of these is seen: therm_sd=1, ss_forced_low=1, or the hotswap in its inrush limit. No new start begins while therm_sd or ss_forced_low is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_mode | input | 1 | 0 = primary-side regulation threshold, 1 = opto-feedback threshold |
| vin_on | input | 1 | Input above turn-on threshold |
| vin_hold | input | 1 | Input above turn-off threshold |
| inrush_ok | input | 1 | Inrush current settled below the inrush limit |
| vcc_rise | input | 1 | VCC above its rising threshold |
| vcc_mid | input | 1 | VCC above its light-load threshold |
| vcc_fall | input | 1 | VCC above its falling threshold |
| ss_low | input | 1 | Soft-start voltage below the discharge-done level |
| ss_psr | input | 1 | Soft-start voltage above the PSR enable level |
| ss_opto | input | 1 | Soft-start voltage above the opto enable level |
| ss_done | input | 1 | Soft-start voltage above the end-of-soft-start level |
| line_ok | input | 1 | Line monitor reports no undervoltage |
| ss_forced_low | input | 1 | Soft-start pin externally forced low |
| therm_sd | input | 1 | Converter thermal shutdown |
| hs_en | output | 1 | Hotswap switch enable |
| ilim_oper | output | 1 | Current-limit select, 1 = operational |
| start_en | output | 1 | VCC startup source enable |
| ss_dis | output | 1 | Soft-start controlled discharge |
| ss_chg | output | 1 | Soft-start charge |
| sw_en | output | 1 | Converter switching enable |

## Verification
A wrong hotswap state shows as a bad pair of hs_en and ilim_oper one edge after the causing flag. It also shows as a pre-discharge that starts too early or never starts, measured against the exact inrush cycle count. A wrong converter state shows at the four converter outputs as a pattern decoded from the state. This includes a skipped ss_dis pulse, a threshold taken from the wrong mode, or a top-up that ends at the wrong cycle. Each of these appears on the edge after the causing flag, and the bench samples exactly there. The long stretches (inrush time and top-up length) are checked at the edge before the boundary and at the boundary itself.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [1:0] {
    HS_OFF    = 2'd0,
    HS_INRUSH = 2'd1,
    HS_OPER   = 2'd2
  } hs_state_e;

  typedef enum logic [2:0] {
    CV_IDLE   = 3'd0,
    CV_DISCH  = 3'd1,
    CV_CHARGE = 3'd2,
    CV_SOFT   = 3'd3,
    CV_RUN    = 3'd4,
    CV_TOPUP  = 3'd5
  } cv_state_e;

  typedef struct packed {
    logic start_en;
    logic ss_dis;
    logic ss_chg;
    logic sw_en;
  } cv_out_t;

  // Output pattern of each converter state; in idle the startup source
  // follows the hotswap so VCC can charge during inrush.
  function automatic cv_out_t cv_decode(input cv_state_e st, input logic hs_on);
    cv_out_t o;
    o = '0;
    case (st)
      CV_IDLE:   o.start_en = hs_on;
      CV_DISCH:  begin o.start_en = 1'b1; o.ss_dis = 1'b1; end
      CV_CHARGE: begin o.start_en = 1'b1; o.ss_chg = 1'b1; end
      CV_SOFT:   begin o.start_en = 1'b1; o.ss_chg = 1'b1; o.sw_en = 1'b1; end
      CV_RUN:    begin o.ss_chg = 1'b1; o.sw_en = 1'b1; end
      CV_TOPUP:  begin o.start_en = 1'b1; o.ss_chg = 1'b1; o.sw_en = 1'b1; end
      default:   o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pd_cycle_timer.sv
module pd_cycle_timer #(
  parameter int LIMIT = 84
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + W'(1);
  end

  assign done = (cnt == LIM);

endmodule

// File: rtl/pd_hotswap_ctl.sv
module pd_hotswap_ctl
  import pd_seq_pkg::*;
#(
  parameter int INRUSH_CYC = 84
) (
  input  logic clk,
  input  logic rst,
  input  logic vin_on,
  input  logic vin_hold,
  input  logic inrush_ok,
  output logic hs_en,
  output logic ilim_oper,
  output logic hs_on,
  output logic hs_inrush,
  output logic inrush_end
);
  hs_state_e st, nxt;
  logic      tmr_done;

  always_comb begin
    nxt = st;
    case (st)
      HS_OFF:    if (vin_on) nxt = HS_INRUSH;
      HS_INRUSH: if (!vin_hold) nxt = HS_OFF;
                 else if (inrush_ok) nxt = HS_OPER;
      HS_OPER:   if (!vin_hold) nxt = HS_OFF;
      default:   nxt = HS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= HS_OFF;
      hs_en     <= 1'b0;
      ilim_oper <= 1'b0;
    end else begin
      st        <= nxt;
      hs_en     <= (nxt != HS_OFF);
      ilim_oper <= (nxt == HS_OPER);
    end
  end

  // Minimum inrush time, counted from the edge the switch closes.
  pd_cycle_timer #(.LIMIT(INRUSH_CYC)) u_inrush_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (st == HS_OFF),
    .done (tmr_done)
  );

  assign hs_on      = (st != HS_OFF);
  assign hs_inrush  = (st == HS_INRUSH);
  assign inrush_end = (st == HS_OPER) && tmr_done;

  p_off_below_on_r1: assert property (@(posedge clk) disable iff (rst)
    (!hs_en && !vin_on) |=> !hs_en);

  p_ilim_after_settle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ilim_oper) |-> $past(inrush_ok));

  p_hs_off_on_drop_r10: assert property (@(posedge clk) disable iff (rst)
    !vin_hold |=> (!hs_en && !ilim_oper));

endmodule

// File: rtl/pd_conv_ctl.sv
module pd_conv_ctl
  import pd_seq_pkg::*;
#(
  parameter int TOPUP_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_mode,
  input  logic hs_on,
  input  logic hs_inrush,
  input  logic inrush_end,
  input  logic vcc_rise,
  input  logic vcc_mid,
  input  logic vcc_fall,
  input  logic ss_low,
  input  logic ss_psr,
  input  logic ss_opto,
  input  logic ss_done,
  input  logic line_ok,
  input  logic ss_forced_low,
  input  logic therm_sd,
  output logic start_en,
  output logic ss_dis,
  output logic ss_chg,
  output logic sw_en
);
  localparam int TOPUP_LIM = (TOPUP_CYC < 2) ? 1 : TOPUP_CYC - 1;

  cv_state_e st, nxt;
  cv_out_t   o_nxt;
  logic      stop_req, start_ok, ss_on_thr, topup_done;

  assign ss_on_thr = fb_mode ? ss_opto : ss_psr;
  assign stop_req  = !vcc_fall || hs_inrush || ss_forced_low || therm_sd ||
                     (!hs_on && !line_ok);
  assign start_ok  = inrush_end && vcc_rise && !stop_req;

  always_comb begin
    nxt = st;
    if (st != CV_IDLE && stop_req) begin
      nxt = CV_IDLE;
    end else begin
      case (st)
        CV_IDLE:   if (start_ok) nxt = CV_DISCH;
        CV_DISCH:  if (ss_low) nxt = CV_CHARGE;
        CV_CHARGE: if (ss_on_thr) nxt = CV_SOFT;
        CV_SOFT:   if (ss_done) nxt = CV_RUN;
        CV_RUN:    if (!vcc_mid) nxt = CV_TOPUP;
        CV_TOPUP:  if (topup_done || vcc_rise) nxt = CV_RUN;
        default:   nxt = CV_IDLE;
      endcase
    end
  end

  assign o_nxt = cv_decode(nxt, hs_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CV_IDLE;
      start_en <= 1'b0;
      ss_dis   <= 1'b0;
      ss_chg   <= 1'b0;
      sw_en    <= 1'b0;
    end else begin
      st       <= nxt;
      start_en <= o_nxt.start_en;
      ss_dis   <= o_nxt.ss_dis;
      ss_chg   <= o_nxt.ss_chg;
      sw_en    <= o_nxt.sw_en;
    end
  end

  // Light-load top-up length.
  pd_cycle_timer #(.LIMIT(TOPUP_LIM)) u_topup_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (st != CV_TOPUP),
    .done (topup_done)
  );

  p_start_gated_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_dis) |-> $past(inrush_end && vcc_rise));

  p_charge_after_dis_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_chg) |-> $past(ss_dis));

  p_mode_thr_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> $past(fb_mode ? ss_opto : ss_psr));

  p_vcc_collapse_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_en && !vcc_fall) |=> !sw_en);

  p_thermal_stop_r11: assert property (@(posedge clk) disable iff (rst)
    (therm_sd || ss_forced_low) |=> (!sw_en && !ss_dis));

endmodule

// File: rtl/pd_start_seq.sv
module pd_start_seq #(
  parameter int CLK_HZ    = 25_000_000,
  parameter int INRUSH_MS = 84,
  parameter int TOPUP_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_mode,
  input  logic vin_on,
  input  logic vin_hold,
  input  logic inrush_ok,
  input  logic vcc_rise,
  input  logic vcc_mid,
  input  logic vcc_fall,
  input  logic ss_low,
  input  logic ss_psr,
  input  logic ss_opto,
  input  logic ss_done,
  input  logic line_ok,
  input  logic ss_forced_low,
  input  logic therm_sd,
  output logic hs_en,
  output logic ilim_oper,
  output logic start_en,
  output logic ss_dis,
  output logic ss_chg,
  output logic sw_en
);
  localparam int INRUSH_CYC = (CLK_HZ / 1000) * INRUSH_MS;

  logic hs_on, hs_inrush, inrush_end;

  pd_hotswap_ctl #(.INRUSH_CYC(INRUSH_CYC)) u_hs (
    .clk        (clk),
    .rst        (rst),
    .vin_on     (vin_on),
    .vin_hold   (vin_hold),
    .inrush_ok  (inrush_ok),
    .hs_en      (hs_en),
    .ilim_oper  (ilim_oper),
    .hs_on      (hs_on),
    .hs_inrush  (hs_inrush),
    .inrush_end (inrush_end)
  );

  pd_conv_ctl #(.TOPUP_CYC(TOPUP_CYC)) u_cv (
    .clk           (clk),
    .rst           (rst),
    .fb_mode       (fb_mode),
    .hs_on         (hs_on),
    .hs_inrush     (hs_inrush),
    .inrush_end    (inrush_end),
    .vcc_rise      (vcc_rise),
    .vcc_mid       (vcc_mid),
    .vcc_fall      (vcc_fall),
    .ss_low        (ss_low),
    .ss_psr        (ss_psr),
    .ss_opto       (ss_opto),
    .ss_done       (ss_done),
    .line_ok       (line_ok),
    .ss_forced_low (ss_forced_low),
    .therm_sd      (therm_sd),
    .start_en      (start_en),
    .ss_dis        (ss_dis),
    .ss_chg        (ss_chg),
    .sw_en         (sw_en)
  );

  p_no_sw_in_inrush_r2: assert property (@(posedge clk) disable iff (rst)
    (hs_en && !ilim_oper) |=> !sw_en);

endmodule

// File: tb/sim_pd_start_seq.sv
module sim_pd_start_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_mode, vin_on, vin_hold, inrush_ok, vcc_rise, vcc_mid, vcc_fall;
  logic ss_low, ss_psr, ss_opto, ss_done, line_ok, ss_forced_low, therm_sd;
  logic hs_en, ilim_oper, start_en, ss_dis, ss_chg, sw_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_start_seq #(.CLK_HZ(1000), .INRUSH_MS(84), .TOPUP_CYC(8)) u0 (
    .clk(clk), .rst(rst), .fb_mode(fb_mode), .vin_on(vin_on), .vin_hold(vin_hold),
    .inrush_ok(inrush_ok), .vcc_rise(vcc_rise), .vcc_mid(vcc_mid), .vcc_fall(vcc_fall),
    .ss_low(ss_low), .ss_psr(ss_psr), .ss_opto(ss_opto), .ss_done(ss_done),
    .line_ok(line_ok), .ss_forced_low(ss_forced_low), .therm_sd(therm_sd),
    .hs_en(hs_en), .ilim_oper(ilim_oper), .start_en(start_en), .ss_dis(ss_dis),
    .ss_chg(ss_chg), .sw_en(sw_en)
  );

  // Row: inputs {fb_mode,vin_on,vin_hold,inrush_ok,vcc_rise,vcc_mid,vcc_fall,
  //              ss_low,ss_psr,ss_opto,ss_done,line_ok,ss_forced_low,therm_sd},
  // edges to hold, expected {hs_en,ilim_oper,start_en,ss_dis,ss_chg,sw_en}, req.
  localparam logic [NVEC-1:0][31:0] VEC = {
    {14'b01101110101100, 8'd1,  6'b101000, 4'd11}, // 35 R11 inrush limit stops converter
    {14'b01101110101100, 8'd1,  6'b100011, 4'd11}, // 34 R11 hotswap back in inrush
    {14'b00001110101100, 8'd1,  6'b000011, 4'd10}, // 33 R10 input lost, line ok
    {14'b01111110101100, 8'd1,  6'b110011, 4'd7},  // 32 R7
    {14'b01111110100100, 8'd1,  6'b111011, 4'd6},  // 31 R6
    {14'b01111111000100, 8'd1,  6'b111010, 4'd5},  // 30 R5
    {14'b01111110100100, 8'd1,  6'b111100, 4'd11}, // 29 R11 restart after release
    {14'b01111110100110, 8'd2,  6'b111000, 4'd11}, // 28 R11 forced low blocks start
    {14'b01111110100101, 8'd1,  6'b111000, 4'd11}, // 27 R11 thermal stop
    {14'b01111110100100, 8'd1,  6'b111011, 4'd6},  // 26 R6
    {14'b01111111000100, 8'd1,  6'b111010, 4'd8},  // 25 R8
    {14'b01111110101100, 8'd1,  6'b111100, 4'd8},  // 24 R8 hiccup pre-discharge
    {14'b01110000101100, 8'd1,  6'b111000, 4'd8},  // 23 R8 VCC collapse
    {14'b01111110101100, 8'd1,  6'b110011, 4'd7},  // 22 R7
    {14'b01111110100100, 8'd1,  6'b111011, 4'd6},  // 21 R6 PSR threshold
    {14'b01111111000100, 8'd1,  6'b111010, 4'd5},  // 20 R5
    {14'b11111110111100, 8'd84, 6'b111100, 4'd4},  // 19 R4 pre-discharge with SS high
    {14'b11111110111100, 8'd2,  6'b111000, 4'd2},  // 18 R2 second power-up
    {14'b10011110111000, 8'd1,  6'b000000, 4'd10}, // 17 R10 line low stops
    {14'b10011110111100, 8'd2,  6'b000011, 4'd10}, // 16 R10 converter keeps running
    {14'b11111110111100, 8'd1,  6'b110011, 4'd9},  // 15 R9 early end on vcc_rise
    {14'b11110010111100, 8'd1,  6'b111011, 4'd9},  // 14 R9
    {14'b11110110111100, 8'd2,  6'b110011, 4'd9},  // 13 R9
    {14'b11110010111100, 8'd1,  6'b110011, 4'd9},  // 12 R9 top-up ends at 8 cycles
    {14'b11110010111100, 8'd7,  6'b111011, 4'd9},  // 11 R9
    {14'b11110010111100, 8'd1,  6'b111011, 4'd9},  // 10 R9 top-up starts
    {14'b11111110111100, 8'd1,  6'b110011, 4'd7},  // 9  R7
    {14'b11111110110100, 8'd1,  6'b111011, 4'd6},  // 8  R6 opto threshold
    {14'b11111110100100, 8'd3,  6'b111010, 4'd6},  // 7  R6 PSR flag ignored
    {14'b11111111000100, 8'd1,  6'b111010, 4'd5},  // 6  R5
    {14'b01111110000100, 8'd1,  6'b111100, 4'd4},  // 5  R4 boundary
    {14'b01111110000100, 8'd3,  6'b111000, 4'd4},  // 4  R4 one edge before
    {14'b01111110000100, 8'd60, 6'b111000, 4'd4},  // 3  R4
    {14'b01111110000100, 8'd20, 6'b111000, 4'd3},  // 2  R3
    {14'b01100000000100, 8'd2,  6'b101000, 4'd2},  // 1  R2
    {14'b00000000000100, 8'd3,  6'b000000, 4'd1}   // 0  R1
  };

  task automatic apply(input logic [13:0] v);
    {fb_mode, vin_on, vin_hold, inrush_ok, vcc_rise, vcc_mid, vcc_fall,
     ss_low, ss_psr, ss_opto, ss_done, line_ok, ss_forced_low, therm_sd} = v;
  endtask

  task automatic check(input logic [5:0] exp, input int req, input string what);
    logic [5:0] got;
    got = {hs_en, ilim_oper, start_en, ss_dis, ss_chg, sw_en};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  initial begin
    apply(14'b00000000000100);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][31:18]);
      repeat (int'(VEC[i][17:10])) @(posedge clk);
      @(negedge clk);
      check(VEC[i][9:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end
    // R1: reset while powered clears every output
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(6'b000000, 1, "R1 reset in run");
    // R1: vin_hold alone does not close the hotswap
    apply(14'b00101110000100);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(6'b000000, 1, "R1 hold without turn-on");
    // R2: turn-on into inrush limit
    apply(14'b01101110000100);
    @(posedge clk);
    @(negedge clk);
    check(6'b100000, 2, "R2 inrush entry");
    // R10: drop during inrush opens the switch, startup source follows
    apply(14'b00001110000100);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(6'b000000, 10, "R10 drop in inrush");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule